// File: doc/BRIEF.md
# Single-Precision Pack and Round Unit

This unit turns an unpacked floating-point operand into a 32-bit IEEE-754 single-precision word. The operand has five parts: a class code, a sign, a two's-complement unbiased exponent and a 32-bit working fraction. For ordinary numbers, bit 30 of the fraction is the explicit leading one, bits 29..7 are the stored mantissa and bits 6..0 are guard bits. The unit encodes the special classes directly. Ordinary numbers are rounded to nearest with ties to even, and carries out of the mantissa are renormalised. Exponents that are too large saturate to infinity. Exponents that are too small become denormals through a right shift, or flush to a signed zero.

The result is registered once. An operand presented with `in_valid` high shows up on `out_word` one clock later with `out_valid` high. When `in_valid` is low, the output word holds its last value.

Top module: `fpk_pack_round`

## Requirements
- R1: Class code 0 (zero), and the unused codes 5, 6 and 7, produce the word {sign, 8'h00, 23'h0}, with the input sign kept.
- R2: Class code 2 (infinity) produces {sign, 8'hFF, 23'h0}.
- R3: Class codes 3 (quiet NaN) and 4 (signalling NaN) produce sign 1, exponent 8'hFF and mantissa in_frac[29:7]. If that payload is zero, mantissa bit 22 is set instead, so the word still encodes a NaN.
- R4: For class code 1 (number, with in_frac[31]=0 and in_frac[30]=1) and an exponent in -126..127, the word's exponent field is exponent+127 and its mantissa is the rounded in_frac[29:7].
- R5: Rounding looks at the guard field in_frac[6:0]. Above 0x40 the value rounds up, below 0x40 it rounds down, and at exactly 0x40 it rounds up only if in_frac[7] is 1.
- R6: If rounding carries into bit 31, the exponent field goes up by one and the mantissa shifts right by one. At exponent 127 this gives infinity.
- R7: A number whose exponent is greater than 127 produces infinity carrying the input sign.
- R8: A number whose exponent is below -126 is shifted right by (-126 - exponent), with the bits that leave bit 0 discarded. It is then rounded as in R5 and emitted with exponent field 0. If rounding reaches the leading-one position, the exponent field becomes 1.
- R9: When the R8 shift would exceed 25 (exponent below -151), the result is a zero carrying the input sign.
- R10: After reset, out_valid and out_word are 0. out_valid is in_valid delayed by one clock. out_word changes only on clocks where in_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_frac | input | 32 | Working fraction: leading one at bit 30, guards at bits 6..0 |
| out_valid | output | 1 | out_word carries a new result |
| out_word | output | 32 | Packed single-precision word |

## Verification
The hardest conditions to reach are the narrow ones where rounding changes the exponent field: a denormal that rounds up into the smallest normal, and an all-ones mantissa at exponent 127 that rounds into infinity. Uniform random fractions almost never hit an exact 0x40 guard tie, and almost never produce a shift that leaves the tie sitting at the bit-0 boundary. Directed operands therefore place all-ones mantissas and exact ties at exponents -127, -150, -151, -152 and 127. The random stimulus also forces the guard field to 0x40 on a quarter of its operands and spreads exponents across both saturation ranges.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int GRD_W  = 7;
    localparam int IEXP_W = 10;

    localparam int FRAC_W = MAN_W + GRD_W + 2;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } fp_word_t;

    function automatic logic class_is_nan(input logic [2:0] c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fpk_align.sv
module fpk_align #(
    parameter int EXP_W  = fpk_pkg::EXP_W,
    parameter int MAN_W  = fpk_pkg::MAN_W,
    parameter int GRD_W  = fpk_pkg::GRD_W,
    parameter int IEXP_W = fpk_pkg::IEXP_W
) (
    input  logic [IEXP_W-1:0]             exp_i,
    input  logic [MAN_W+GRD_W+1:0]        frac_i,
    output logic                          ovf_o,
    output logic                          sub_o,
    output logic [MAN_W+GRD_W+1:0]        frac_o,
    output logic [EXP_W-1:0]              bexp_o
);
    localparam int FRAC_W = MAN_W + GRD_W + 2;
    localparam int EXT_W  = IEXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    localparam logic signed [EXT_W-1:0] BIAS_V = EXT_W'(BIAS);
    localparam logic signed [EXT_W-1:0] EMIN_V = EXT_W'(1 - BIAS);
    localparam logic signed [EXT_W-1:0] LIM_V  = EXT_W'(FRAC_W - GRD_W);

    logic signed [EXT_W-1:0] e_x;
    logic signed [EXT_W-1:0] shamt;
    logic signed [EXT_W-1:0] biased;
    logic                    too_far;

    always_comb begin
        e_x     = {{2{exp_i[IEXP_W-1]}}, exp_i};
        ovf_o   = e_x > BIAS_V;
        sub_o   = e_x < EMIN_V;
        shamt   = EMIN_V - e_x;
        too_far = shamt > LIM_V;
        biased  = e_x + BIAS_V;
        bexp_o  = sub_o ? '0 : biased[EXP_W-1:0];
        if (!sub_o)
            frac_o = frac_i;
        else if (too_far)
            frac_o = '0;
        else
            frac_o = frac_i >> shamt;
    end
endmodule

// File: rtl/fpk_round.sv
module fpk_round #(
    parameter int FRAC_W = fpk_pkg::FRAC_W,
    parameter int GRD_W  = fpk_pkg::GRD_W
) (
    input  logic [FRAC_W-1:0]       frac_i,
    output logic [FRAC_W-GRD_W-1:0] rnd_o
);
    localparam int RW = FRAC_W - GRD_W;
    localparam logic [GRD_W-1:0] HALF = GRD_W'(1 << (GRD_W - 1));

    logic [GRD_W-1:0] g;
    logic [RW-1:0]    keep;
    logic             up;

    always_comb begin
        g     = frac_i[GRD_W-1:0];
        keep  = frac_i[FRAC_W-1:GRD_W];
        up    = (g > HALF) || ((g == HALF) && keep[0]);
        rnd_o = keep + RW'(up);
    end

    // R5
    always_comb begin
        if ((g == HALF) && !keep[0])
            tie_even_chk: assert (rnd_o == keep);
    end
endmodule

// File: rtl/fpk_pack_round.sv
module fpk_pack_round
    import fpk_pkg::*;
#(
    parameter int P_EXP_W  = fpk_pkg::EXP_W,
    parameter int P_MAN_W  = fpk_pkg::MAN_W,
    parameter int P_GRD_W  = fpk_pkg::GRD_W,
    parameter int P_IEXP_W = fpk_pkg::IEXP_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [2:0]                       in_class,
    input  logic                             in_sign,
    input  logic [P_IEXP_W-1:0]              in_exp,
    input  logic [P_MAN_W+P_GRD_W+1:0]       in_frac,
    output logic                             out_valid,
    output logic [P_EXP_W+P_MAN_W:0]         out_word
);
    localparam int L_FRAC_W = P_MAN_W + P_GRD_W + 2;
    localparam int L_WORD_W = 1 + P_EXP_W + P_MAN_W;
    localparam int L_RW     = L_FRAC_W - P_GRD_W;
    localparam int L_BIAS   = (1 << (P_EXP_W - 1)) - 1;
    localparam int L_FLUSH  = 1 - L_BIAS - L_RW;

    logic                    ovf, sub;
    logic [L_FRAC_W-1:0]     frac_al;
    logic [P_EXP_W-1:0]      bexp;
    logic [L_RW-1:0]         rnd;
    logic [L_WORD_W-1:0]     nxt;
    logic [P_MAN_W-1:0]      payload;

    fpk_align #(
        .EXP_W (P_EXP_W),
        .MAN_W (P_MAN_W),
        .GRD_W (P_GRD_W),
        .IEXP_W(P_IEXP_W)
    ) u_align (
        .exp_i (in_exp),
        .frac_i(in_frac),
        .ovf_o (ovf),
        .sub_o (sub),
        .frac_o(frac_al),
        .bexp_o(bexp)
    );

    fpk_round #(
        .FRAC_W(L_FRAC_W),
        .GRD_W (P_GRD_W)
    ) u_round (
        .frac_i(frac_al),
        .rnd_o (rnd)
    );

    always_comb begin
        payload = in_frac[L_FRAC_W-3:P_GRD_W];
        if (payload == '0)
            payload[P_MAN_W-1] = 1'b1;
    end

    always_comb begin
        nxt = '0;
        nxt[L_WORD_W-1] = in_sign;
        case (in_class)
            CLS_NUM: begin
                if (ovf) begin
                    nxt[L_WORD_W-2:P_MAN_W] = '1;
                end else if (sub) begin
                    nxt[L_WORD_W-2:P_MAN_W] = P_EXP_W'(rnd[L_RW-2]);
                    nxt[P_MAN_W-1:0]        = rnd[P_MAN_W-1:0];
                end else if (rnd[L_RW-1]) begin
                    nxt[L_WORD_W-2:P_MAN_W] = bexp + 1'b1;
                    nxt[P_MAN_W-1:0]        = rnd[P_MAN_W:1];
                end else begin
                    nxt[L_WORD_W-2:P_MAN_W] = bexp;
                    nxt[P_MAN_W-1:0]        = rnd[P_MAN_W-1:0];
                end
            end
            CLS_INF: nxt[L_WORD_W-2:P_MAN_W] = '1;
            CLS_QNAN, CLS_SNAN: begin
                nxt[L_WORD_W-1]         = 1'b1;
                nxt[L_WORD_W-2:P_MAN_W] = '1;
                nxt[P_MAN_W-1:0]        = payload;
            end
            default: nxt[L_WORD_W-2:0] = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= nxt;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid) |=> out_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> !out_valid);
    // R10
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !in_valid) |=> $stable(out_word));
    // R7
    exp_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_class == CLS_NUM && $signed(in_exp) > L_BIAS)
        |=> out_word[L_WORD_W-2:0] == {{P_EXP_W{1'b1}}, {P_MAN_W{1'b0}}});
    // R3
    nan_form_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && class_is_nan(in_class))
        |=> (out_word[L_WORD_W-1] && (&out_word[L_WORD_W-2:P_MAN_W])
             && (|out_word[P_MAN_W-1:0])));
    // R9
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_class == CLS_NUM && $signed(in_exp) < L_FLUSH)
        |=> (out_word[L_WORD_W-2:0] == '0 && out_word[L_WORD_W-1] == $past(in_sign)));
endmodule

// File: tb/tb_fpk_pack_round.sv
module tb_fpk_pack_round;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_class;
    logic        in_sign;
    logic [9:0]  in_exp;
    logic [31:0] in_frac;
    logic        out_valid;
    logic [31:0] out_word;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpk_pack_round dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic longint rne(longint v);
        longint q = v / 128;
        longint g = v % 128;
        if (g > 64 || (g == 64 && (q % 2) == 1)) q = q + 1;
        return q;
    endfunction

    function automatic logic [31:0] model(logic [2:0] c, logic s, int e, logic [31:0] f);
        logic [31:0] w;
        longint b;
        int sh;
        logic [22:0] p;
        case (c)
            3'd1: begin
                if (e > 127) w = {s, 8'hFF, 23'h0};
                else if (e < -126) begin
                    sh = -126 - e;
                    b  = (sh > 25) ? 64'd0 : (longint'(f) >> sh);
                    b  = rne(b);
                    w  = {s, 7'b0, b[23], b[22:0]};
                end else begin
                    b = rne(longint'(f));
                    if (b >= (64'd1 << 24)) w = {s, 8'(e + 128), b[23:1]};
                    else                    w = {s, 8'(e + 127), b[22:0]};
                end
            end
            3'd2: w = {s, 8'hFF, 23'h0};
            3'd3, 3'd4: begin
                p = f[29:7];
                if (p == 23'h0) p = 23'h400000;
                w = {1'b1, 8'hFF, p};
            end
            default: w = {s, 31'h0};
        endcase
        return w;
    endfunction

    function automatic string tag_of(logic [2:0] c, int e);
        if (c == 3'd1) begin
            if (e > 127)  return "R7";
            if (e < -151) return "R9";
            if (e < -126) return "R8";
            return "R4";
        end
        if (c == 3'd2) return "R2";
        if (c == 3'd3 || c == 3'd4) return "R3";
        return "R1";
    endfunction

    task automatic check(string tag, logic [31:0] exp_w);
        n_chk++;
        if (out_valid !== 1'b1 || out_word !== exp_w) begin
            n_err++;
            $display("FAIL %s: got valid=%0b word=%08h, expected valid=1 word=%08h",
                     tag, out_valid, out_word, exp_w);
        end
    endtask

    task automatic send(logic [2:0] c, logic s, int e, logic [31:0] f,
                        string tag, logic [31:0] exp_w);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_sign = s; in_exp = 10'(e); in_frac = f;
        @(negedge clk);
        check(tag, exp_w);
    endtask

    task automatic send_m(logic [2:0] c, logic s, int e, logic [31:0] f);
        send(c, s, e, f, tag_of(c, e), model(c, s, e, f));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        rst = 1'b1; in_valid = 1'b0; in_class = 3'd0; in_sign = 1'b0;
        in_exp = '0; in_frac = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        n_chk++;
        if (out_valid !== 1'b0 || out_word !== 32'h0) begin
            n_err++;
            $display("FAIL R10 reset: got valid=%0b word=%08h, expected 0/00000000", out_valid, out_word);
        end
        rst = 1'b0;

        send(3'd0, 1'b1, 5, 32'h4000_1234, "R1 signed zero", 32'h8000_0000);
        send(3'd6, 1'b0, 3, 32'h7FFF_FFFF, "R1 reserved class", 32'h0000_0000);
        send(3'd2, 1'b1, 0, 32'h0, "R2 inf", 32'hFF80_0000);
        send(3'd3, 1'b0, 0, 32'h4000_0080, "R3 qnan payload", 32'hFF80_0001);
        send(3'd4, 1'b0, 0, 32'h0000_007F, "R3 empty payload", 32'hFFC0_0000);
        send(3'd1, 1'b0, 0, 32'h4000_0000, "R4 one", 32'h3F80_0000);
        send(3'd1, 1'b1, -126, 32'h4000_0000, "R4 min normal", 32'h8080_0000);
        send(3'd1, 1'b0, 0, 32'h4000_0040, "R5 tie even down", 32'h3F80_0000);
        send(3'd1, 1'b0, 0, 32'h4000_00C0, "R5 tie odd up", 32'h3F80_0002);
        send(3'd1, 1'b0, 0, 32'h4000_0041, "R5 above half", 32'h3F80_0001);
        send(3'd1, 1'b0, 0, 32'h4000_003F, "R5 below half", 32'h3F80_0000);
        send(3'd1, 1'b0, 0, 32'h7FFF_FFC0, "R6 carry renorm", 32'h4000_0000);
        send(3'd1, 1'b0, 127, 32'h7FFF_FFC0, "R6 carry to inf", 32'h7F80_0000);
        send(3'd1, 1'b1, 128, 32'h4000_0000, "R7 overflow", 32'hFF80_0000);
        send(3'd1, 1'b0, -127, 32'h4000_0000, "R8 half denormal", 32'h0040_0000);
        send(3'd1, 1'b0, -149, 32'h4000_0000, "R8 smallest denormal", 32'h0000_0001);
        send(3'd1, 1'b0, -150, 32'h4000_0000, "R8 tie to zero", 32'h0000_0000);
        send(3'd1, 1'b0, -150, 32'h7FFF_FFFF, "R8 round up to lsb", 32'h0000_0001);
        send(3'd1, 1'b0, -127, 32'h7FFF_FFFF, "R8 round into normal", 32'h0080_0000);
        send(3'd1, 1'b0, -151, 32'h7FFF_FFFF, "R8 shift 25", 32'h0000_0000);
        send(3'd1, 1'b1, -152, 32'h7FFF_FFFF, "R9 flush", 32'h8000_0000);

        // R10: hold when in_valid is low
        last = out_word;
        @(negedge clk);
        in_valid = 1'b0; in_class = 3'd2; in_sign = 1'b0; in_exp = '0; in_frac = '0;
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_word !== last) begin
            n_err++;
            $display("FAIL R10 hold: got valid=%0b word=%08h, expected valid=0 word=%08h",
                     out_valid, out_word, last);
        end

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  c;
            logic [31:0] f;
            int e;
            int sel = int'($urandom_range(0, 9));
            if (sel < 8) c = 3'd1;
            else c = 3'($urandom_range(0, 7));
            e = int'($urandom_range(0, 310)) - 170;
            f = {2'b01, 30'($urandom)};
            if ($urandom_range(0, 3) == 0) f[6:0] = 7'h40;
            if ($urandom_range(0, 7) == 0) f[29:7] = '1;
            send_m(c, 1'($urandom), e, f);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule